// File: doc/BRIEF.md
# Serial-Bus Parallel Port Expander With Shared Converter Registers

This block is a two-wire serial slave that splits its resources between a general-purpose parallel port and a bank of 8-bit converter setting registers. The slave address is the fixed pattern 1001 followed by three strap pins. The most significant strap also picks the partition. When it is low the device has an 8-bit port and four converter channels. When it is high it has a 4-bit port (bits 3..0) and eight converter channels.

A write transaction carries a target byte after the address. The low nibble of that byte chooses one of four things: a single port write, one converter channel, a continuous port stream, or nothing. A read transaction has no target byte. Every byte it returns is a new sample of the port input pins. The port turns to high impedance when a read begins and stays that way until a later port write is acknowledged.

The serial lines are sampled with the system clock and passed through a synchronizer. SDA is driven open-drain through a pull-low output.

Top module: `pio_dac_bridge`

## Requirements
- R1: The slave acknowledges only the 7-bit address {1001, strap[2:0]}. Any other address gets no acknowledge, and the data bytes that follow change nothing.
- R2: After reset, pin_oe is 0x00, pin_out is 0x00 and every converter register reads 0x00.
- R3: With target codes 1 to 4 (low nibble), the first data byte goes to converter channel 1 to 4. Later data bytes in the same transaction have no effect.
- R4: Codes 5 to 8 write converter channels 5 to 8 only when strap[2]=1. When strap[2]=0 those channels never change.
- R5: Codes 9 to 14 change nothing. The upper nibble of the target byte is never decoded.
- R6: Code 0 is a single port write. The first data byte sets pin_out and asserts pin_oe on the port bits. Later bytes in the same transaction are ignored.
- R7: Code 15 is a continuous port write. Every data byte updates pin_out in turn until STOP or START.
- R8: With strap[2]=1, the upper four bits of written bytes are dropped: pin_out[7:4] and pin_oe[7:4] stay 0. The upper four bits of read bytes are returned as 0.
- R9: On a read, each byte is a new sample of pin_in. The sample is taken at the SCL falling edge that starts the byte's first bit. Reading continues while the master acknowledges.
- R10: A master NACK ends a read. The slave stops driving SDA until the next START or STOP.
- R11: pin_oe drops to 0 when a read is accepted. It stays 0 until a later port write is acknowledged.
- R12: A port write takes effect at the end of the ACK clock of its data byte. pin_out has not changed while that ACK clock is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap | input | 3 | Address straps; bit 2 also selects the port/converter split |
| pin_in | input | 8 | Parallel port input levels |
| pin_out | output | 8 | Parallel port output data |
| pin_oe | output | 8 | Per-bit output enable of the parallel port |
| dac_level | output | 64 | Eight 8-bit converter settings; channel n is in bits [8n-1:8n-8] |

## Verification
The case that is hardest to reach from the ports is the fresh sample taken for each read byte. It happens exactly at the SCL fall that ends the master's acknowledge clock, so the stimulus changes pin_in while that acknowledge clock is high. Only a sample taken at that fall returns the new value; an earlier sample returns the old one. The bench also looks at pin_out while the write ACK clock is still high, to show the update waits for its falling edge. After a NACK it clocks one more byte and expects all ones on the released line.

// File: rtl/pio_dac_pkg.sv
package pio_dac_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] ADDR_FIXED = 4'b1001;

  typedef enum logic [1:0] {TGT_NONE, TGT_PORT_ONE, TGT_PORT_RUN, TGT_DAC} tgt_kind_e;

  typedef struct packed {
    tgt_kind_e  kind;
    logic [2:0] idx;
  } tgt_sel_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CODE, ST_CODE_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_WAIT
  } eng_st_e;

  // Target-code decode: wide_dac opens channels 5..8.
  function automatic tgt_sel_t decode_code(input logic [3:0] code, input logic wide_dac);
    tgt_sel_t s;
    s.kind = TGT_NONE;
    s.idx  = '0;
    if (code == 4'd0)
      s.kind = TGT_PORT_ONE;
    else if (code == 4'd15)
      s.kind = TGT_PORT_RUN;
    else if (code <= 4'd4 || (wide_dac && code <= 4'd8)) begin
      s.kind = TGT_DAC;
      s.idx  = 3'(code - 4'd1);
    end
    return s;
  endfunction

  // Port bits that exist in the selected split.
  function automatic logic [BYTE_W-1:0] port_mask(input logic narrow);
    return narrow ? 8'h0F : 8'hFF;
  endfunction
endpackage

// File: rtl/pdb_line_sync.sv
module pdb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_q,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = STAGES;

  logic [TOP:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_raw};
      sda_sh <= {sda_sh[TOP-1:0], sda_raw};
    end
  end

  logic scl_new, scl_old, sda_new, sda_old;
  assign scl_new = scl_sh[TOP-1];
  assign scl_old = scl_sh[TOP];
  assign sda_new = sda_sh[TOP-1];
  assign sda_old = sda_sh[TOP];

  assign sda_q     = sda_new;
  assign scl_rise  = scl_new & ~scl_old;
  assign scl_fall  = ~scl_new & scl_old;
  assign start_det = scl_new & scl_old & sda_old & ~sda_new;
  assign stop_det  = scl_new & scl_old & ~sda_old & sda_new;
endmodule

// File: rtl/pdb_serial_engine.sv
module pdb_serial_engine
  import pio_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_q,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap,
  input  logic [BYTE_W-1:0] rd_sample,
  output logic              sda_pull,
  output logic              ev_port_wr,
  output logic              ev_dac_wr,
  output logic              ev_sample,
  output logic [BYTE_W-1:0] wr_byte,
  output logic [2:0]        dac_idx,
  output logic              in_wait
);
  eng_st_e           st;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  tgt_sel_t          sel;
  logic              used;
  logic              rd;
  logic              mack;

  logic addr_hit;
  assign addr_hit = (shreg[7:1] == {ADDR_FIXED, strap});
  assign wr_byte  = shreg;
  assign dac_idx  = sel.idx;
  assign in_wait  = (st == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      sel        <= '0;
      used       <= 1'b0;
      rd         <= 1'b0;
      mack       <= 1'b0;
      sda_pull   <= 1'b0;
      ev_port_wr <= 1'b0;
      ev_dac_wr  <= 1'b0;
      ev_sample  <= 1'b0;
    end else begin
      ev_port_wr <= 1'b0;
      ev_dac_wr  <= 1'b0;
      ev_sample  <= 1'b0;
      if (start_det) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_CODE, ST_WDATA: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_q};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == ST_ADDR) begin
                if (addr_hit) begin
                  sda_pull <= 1'b1;
                  rd       <= shreg[0];
                  st       <= ST_ADDR_ACK;
                end else begin
                  st <= ST_WAIT;
                end
              end else if (st == ST_CODE) begin
                sel      <= decode_code(shreg[3:0], strap[2]);
                sda_pull <= 1'b1;
                st       <= ST_CODE_ACK;
              end else begin
                sda_pull <= 1'b1;
                st       <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rd) begin
                shreg     <= rd_sample;
                sda_pull  <= ~rd_sample[7];
                bitcnt    <= 4'd1;
                ev_sample <= 1'b1;
                st        <= ST_RDATA;
              end else begin
                sda_pull <= 1'b0;
                st       <= ST_CODE;
              end
            end
          end
          ST_CODE_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              used     <= 1'b0;
              st       <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_pull   <= 1'b0;
              st         <= ST_WDATA;
              used       <= 1'b1;
              ev_port_wr <= (sel.kind == TGT_PORT_RUN) || (sel.kind == TGT_PORT_ONE && !used);
              ev_dac_wr  <= (sel.kind == TGT_DAC) && !used;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0;
                st       <= ST_RACK;
              end else begin
                sda_pull <= ~shreg[6];
                shreg    <= {shreg[6:0], 1'b0};
                bitcnt   <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_q;
            end else if (scl_fall) begin
              if (mack) begin
                shreg     <= rd_sample;
                sda_pull  <= ~rd_sample[7];
                bitcnt    <= 4'd1;
                ev_sample <= 1'b1;
                st        <= ST_RDATA;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pdb_target_regs.sv
module pdb_target_regs
  import pio_dac_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  narrow,
  input  logic                  ev_port_wr,
  input  logic                  ev_dac_wr,
  input  logic                  ev_sample,
  input  logic [BYTE_W-1:0]     wr_byte,
  input  logic [2:0]            dac_idx,
  output logic [BYTE_W-1:0]     pin_out,
  output logic [BYTE_W-1:0]     pin_oe,
  output logic [NCH*BYTE_W-1:0] dac_level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else if (ev_port_wr) begin
      pin_out <= wr_byte & port_mask(narrow);
      pin_oe  <= port_mask(narrow);
    end else if (ev_sample) begin
      pin_oe <= '0;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dac_level[ch*BYTE_W +: BYTE_W] <= '0;
      else if (ev_dac_wr && dac_idx == 3'(ch))
        dac_level[ch*BYTE_W +: BYTE_W] <= wr_byte;
    end
  end
endmodule

// File: rtl/pio_dac_bridge.sv
module pio_dac_bridge
  import pio_dac_pkg::*;
#(
  parameter int NCH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull,
  input  logic [2:0]            strap,
  input  logic [BYTE_W-1:0]     pin_in,
  output logic [BYTE_W-1:0]     pin_out,
  output logic [BYTE_W-1:0]     pin_oe,
  output logic [NCH*BYTE_W-1:0] dac_level
);
  logic scl_rise, scl_fall, sda_q, start_det, stop_det;
  logic ev_port_wr, ev_dac_wr, ev_sample, in_wait;
  logic [BYTE_W-1:0] wr_byte, rd_sample;
  logic [2:0] dac_idx;

  assign rd_sample = pin_in & port_mask(strap[2]);

  pdb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_q(sda_q),
    .start_det(start_det), .stop_det(stop_det)
  );

  pdb_serial_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_q(sda_q), .start_det(start_det), .stop_det(stop_det),
    .strap(strap), .rd_sample(rd_sample), .sda_pull(sda_pull),
    .ev_port_wr(ev_port_wr), .ev_dac_wr(ev_dac_wr), .ev_sample(ev_sample),
    .wr_byte(wr_byte), .dac_idx(dac_idx), .in_wait(in_wait)
  );

  pdb_target_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .narrow(strap[2]),
    .ev_port_wr(ev_port_wr), .ev_dac_wr(ev_dac_wr), .ev_sample(ev_sample),
    .wr_byte(wr_byte), .dac_idx(dac_idx),
    .pin_out(pin_out), .pin_oe(pin_oe), .dac_level(dac_level)
  );
endmodule

// File: rtl/pdb_checker.sv
module pdb_checker #(
  parameter int NCH = 8,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     strap,
  input logic [W-1:0]   pin_out,
  input logic [W-1:0]   pin_oe,
  input logic [NCH*W-1:0] dac_level,
  input logic           sda_pull,
  input logic           ev_port_wr,
  input logic           ev_dac_wr,
  input logic           ev_sample,
  input logic           in_wait
);
  localparam int HALF = NCH * W / 2;

  assert_narrow_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strap[2] |-> (pin_out[W-1:W/2] == '0 && pin_oe[W-1:W/2] == '0));

  assert_sample_floats_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |=> (pin_oe == '0));

  assert_port_moves_after_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out) |-> $past(ev_port_wr));

  assert_upper_dac_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strap[2] |-> $stable(dac_level[NCH*W-1:HALF]));

  assert_wait_releases_sda_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !sda_pull);

  assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_port_wr, ev_dac_wr, ev_sample}));
endmodule

bind pio_dac_bridge pdb_checker #(.NCH(NCH), .W(8)) u_chk (
  .clk(clk), .rst_n(rst_n), .strap(strap), .pin_out(pin_out), .pin_oe(pin_oe),
  .dac_level(dac_level), .sda_pull(sda_pull), .ev_port_wr(ev_port_wr),
  .ev_dac_wr(ev_dac_wr), .ev_sample(ev_sample), .in_wait(in_wait)
);

// File: tb/pio_dac_bridge_test.sv
module pio_dac_bridge_test;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b010;
  logic [7:0] pin_in = 8'h00;
  logic sda_pull;
  logic [7:0] pin_out, pin_oe;
  logic [63:0] dac_level;
  logic sda_i;
  logic [7:0] snap;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign sda_i = sda_m & ~sda_pull;

  pio_dac_bridge uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i), .sda_pull(sda_pull),
    .strap(strap), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .dac_level(dac_level)
  );

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] s);
    rst_n = 1'b0;
    strap = s;
    wt(5);
    rst_n = 1'b1;
    wt(5);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q);
      scl_m = 1'b1; wt(2*Q);
      scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    acked = ~sda_i;
    snap = pin_out;
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic rd_byte(input logic give_ack, input logic [7:0] nxt, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(Q);
      v[i] = sda_i;
      wt(Q);
      scl_m = 1'b0; wt(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    pin_in = nxt; wt(Q);
    scl_m = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dac(input int ch);
    return dac_level[(ch-1)*8 +: 8];
  endfunction

  task automatic t_reset();
    check("R2 oe", {56'd0, pin_oe}, 64'h0);
    check("R2 out", {56'd0, pin_out}, 64'h0);
    check("R2 dac", dac_level, 64'h0);
  endtask

  task automatic t_address();
    logic a;
    bus_start();
    wr_byte({4'b1001, 3'b011, 1'b0}, a);
    check("R1 foreign address no ack", {63'd0, a}, 64'd0);
    wr_byte(8'h00, a);
    wr_byte(8'hFF, a);
    bus_stop();
    check("R1 foreign write no port change", {48'd0, pin_oe, pin_out}, 64'h0);
    bus_start();
    wr_byte({4'b1001, 3'b010, 1'b0}, a);
    check("R1 own address ack", {63'd0, a}, 64'd1);
    bus_stop();
  endtask

  task automatic t_dac_low();
    logic a;
    bus_start();
    wr_byte({4'b1001, strap, 1'b0}, a);
    wr_byte(8'hA2, a);
    check("R5 code byte ack", {63'd0, a}, 64'd1);
    wr_byte(8'h5C, a);
    check("R3 channel 2 written", {56'd0, dac(2)}, 64'h5C);
    wr_byte(8'h11, a);
    check("R3 second byte ignored", {56'd0, dac(2)}, 64'h5C);
    bus_stop();
    check("R3 others untouched", dac_level & ~64'h0000_0000_0000_FF00, 64'h0);
  endtask

  task automatic t_dac_locked();
    logic a;
    bus_start();
    wr_byte({4'b1001, strap, 1'b0}, a);
    wr_byte(8'h06, a);
    wr_byte(8'h77, a);
    bus_stop();
    check("R4 channel 6 locked when strap2=0", dac_level, 64'h0000_0000_0000_5C00);
  endtask

  task automatic t_dontcare();
    logic a;
    bus_start();
    wr_byte({4'b1001, strap, 1'b0}, a);
    wr_byte(8'h0B, a);
    wr_byte(8'h33, a);
    bus_stop();
    check("R5 code 11 no dac change", dac_level, 64'h0000_0000_0000_5C00);
    check("R5 code 11 no port change", {48'd0, pin_oe, pin_out}, 64'h0);
  endtask

  task automatic t_single_port();
    logic a;
    bus_start();
    wr_byte({4'b1001, strap, 1'b0}, a);
    wr_byte(8'h00, a);
    wr_byte(8'hC3, a);
    check("R12 unchanged during ack clock", {56'd0, snap}, 64'h00);
    check("R6 single write data", {56'd0, pin_out}, 64'hC3);
    check("R6 oe asserted", {56'd0, pin_oe}, 64'hFF);
    wr_byte(8'h3C, a);
    check("R6 second byte ignored", {56'd0, pin_out}, 64'hC3);
    bus_stop();
  endtask

  task automatic t_stream();
    logic a;
    logic [7:0] vals [3] = '{8'h11, 8'h22, 8'h33};
    bus_start();
    wr_byte({4'b1001, strap, 1'b0}, a);
    wr_byte(8'h0F, a);
    foreach (vals[k]) begin
      wr_byte(vals[k], a);
      check("R7 stream byte", {56'd0, pin_out}, {56'd0, vals[k]});
    end
    bus_stop();
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] v;
    pin_in = 8'hA5;
    bus_start();
    wr_byte({4'b1001, strap, 1'b1}, a);
    check("R1 read address ack", {63'd0, a}, 64'd1);
    check("R11 port floats on read", {56'd0, pin_oe}, 64'h00);
    rd_byte(1'b1, 8'h5A, v);
    check("R9 first sample", {56'd0, v}, 64'hA5);
    pin_in = 8'hFF;
    rd_byte(1'b0, 8'h00, v);
    check("R9 fresh sample at ack fall", {56'd0, v}, 64'h5A);
    rd_byte(1'b0, 8'h00, v);
    check("R10 sda released after nack", {56'd0, v}, 64'hFF);
    bus_stop();
    check("R11 still floating after read", {56'd0, pin_oe}, 64'h00);
    check("R11 latch kept", {56'd0, pin_out}, 64'h33);
    bus_start();
    wr_byte({4'b1001, strap, 1'b0}, a);
    wr_byte(8'h00, a);
    wr_byte(8'h99, a);
    bus_stop();
    check("R11 port driven after write", {48'd0, pin_oe, pin_out}, 64'hFF99);
  endtask

  task automatic t_narrow();
    logic a;
    logic [7:0] v;
    do_reset(3'b101);
    t_reset();
    bus_start();
    wr_byte({4'b1001, 3'b101, 1'b0}, a);
    check("R1 strap 101 address ack", {63'd0, a}, 64'd1);
    wr_byte(8'h00, a);
    wr_byte(8'hE7, a);
    bus_stop();
    check("R8 upper write bits dropped", {48'd0, pin_oe, pin_out}, 64'h0F07);
    bus_start();
    wr_byte({4'b1001, 3'b101, 1'b0}, a);
    wr_byte(8'h07, a);
    wr_byte(8'h42, a);
    bus_stop();
    check("R4 channel 7 open when strap2=1", {56'd0, dac(7)}, 64'h42);
    pin_in = 8'hBD;
    bus_start();
    wr_byte({4'b1001, 3'b101, 1'b1}, a);
    rd_byte(1'b0, 8'h00, v);
    bus_stop();
    check("R8 upper read bits zero", {56'd0, v}, 64'h0D);
  endtask

  initial begin
    do_reset(3'b010);
    t_reset();
    t_address();
    t_dac_low();
    t_dac_locked();
    t_dontcare();
    t_single_port();
    t_stream();
    t_read();
    t_narrow();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule